// File: doc/BRIEF.md
# Redundant Link Signal Selector

Two optical links carry identical copies of every 256-bit frame. This block holds the copy from each link until its partner arrives. It checks the CRC-32 of each copy, compares the two CRC fields as received, and applies a fixed eight-entry decision table. The result is one of three actions: pass link A on, pass link B on, or request a beam dump. Each outcome other than "both good and equal" also raises a one-cycle diagnostic trigger with a 3-bit reason code. Downstream logic uses this code to find which link, field or generator is misbehaving.

If one copy arrives and the other does not follow within a bounded wait, the block decides anyway and treats the missing link as a CRC failure. A saturating counter for each table entry records how often that entry was taken.

Top module: `redlink_sel`

## Requirements
- R1: A frame carries its CRC in bits [31:0]. The CRC is computed over bits [FRAME_W-1:32], most significant bit first. It uses polynomial 0x04C11DB7, a start value of all ones, no reflection and no final inversion. A copy is good when the computed CRC equals its field.
- R2: When both links hold a copy, the decision is registered. The outputs change on the clock edge that follows the edge capturing the later copy, or the shared copy if both arrive together.
- R3: The condition pattern is {A good, B good, CRC fields equal}, with bit 2 = A good, bit 1 = B good and bit 0 = fields equal. Pattern 111 pulses out_valid with frame A, and raises neither trigger nor dump.
- R4: Patterns 101 and 100 pulse out_valid with frame A and raise the trigger.
- R5: Patterns 011 and 010 pulse out_valid with frame B and raise the trigger.
- R6: Patterns 000, 001 and 110 pulse dump_req and raise the trigger. In these cases out_valid stays low and out_frame keeps its previous value.
- R7: sw_trig is a one-cycle pulse for each triggering decision. trig_code then takes the pattern value and keeps it until the next trigger.
- R8: A lone copy held for TIMEOUT cycles forces a decision. The missing link counts as failed and the fields count as unequal. The outputs change TIMEOUT edges after the lone copy's capture edge.
- R9: A new copy on a link that already holds one replaces the held copy. The wait timer is not restarted.
- R10: A copy that arrives on the edge where a decision is taken is kept for the next pair. It does not affect the decision being made.
- R11: Each pattern p has an event counter at ev_count[p*CNT_W +: CNT_W]. The counter adds one for each decision with that pattern and stops at 2^CNT_W-1.
- R12: Reset clears out_valid, dump_req, sw_trig, trig_code, out_frame, all held copies and all counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_valid | input | 1 | Frame strobe for link A |
| a_frame | input | FRAME_W | Frame received on link A |
| b_valid | input | 1 | Frame strobe for link B |
| b_frame | input | FRAME_W | Frame received on link B |
| out_valid | output | 1 | One-cycle strobe for a forwarded frame |
| out_frame | output | FRAME_W | Last forwarded frame |
| dump_req | output | 1 | One-cycle dump request |
| sw_trig | output | 1 | One-cycle diagnostic trigger |
| trig_code | output | 3 | Condition pattern of the last trigger |
| ev_count | output | 8*CNT_W | Saturating per-pattern event counters |

## Verification
Two functions can fall in the same cycle: a pair decision, which empties both holding slots, and the capture of a new copy on one link. The bench provokes this by presenting a fresh copy on link A exactly on the edge where a matched pair is being decided. It then judges two things. The decision must carry the old frame A, and the next copy on link B must pair with the fresh A copy rather than wait for a timeout. The timer-based decision is also timed against a replacement arrival to confirm the wait is measured from the first capture.

// File: rtl/redlink_pkg.sv
package redlink_pkg;

  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = '1;
  localparam int PAT_W = 3;
  localparam int N_PAT = 1 << PAT_W;

  typedef logic [PAT_W-1:0] pat_t;

  typedef struct packed {
    logic take_a;
    logic take_b;
    logic dump;
    logic trig;
  } act_t;

  // pattern = {a_good, b_good, fields_equal}
  function automatic act_t decode_pat(input pat_t p);
    act_t a;
    a = '0;
    case (p)
      3'b111: a.take_a = 1'b1;
      3'b101, 3'b100: begin
        a.take_a = 1'b1;
        a.trig   = 1'b1;
      end
      3'b011, 3'b010: begin
        a.take_b = 1'b1;
        a.trig   = 1'b1;
      end
      default: begin
        a.dump = 1'b1;
        a.trig = 1'b1;
      end
    endcase
    return a;
  endfunction

endpackage

// File: rtl/redlink_crc.sv
module redlink_crc
  import redlink_pkg::*;
#(
  parameter int FRAME_W = 256
) (
  input  logic [FRAME_W-1:0] frame,
  output logic               good
);

  always_comb begin : crc_walk
    logic [CRC_W-1:0] c;
    logic             fb;
    c = CRC_SEED;
    for (int i = FRAME_W - 1; i >= CRC_W; i--) begin
      fb = c[CRC_W-1] ^ frame[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    good = (c == frame[CRC_W-1:0]);
  end

endmodule

// File: rtl/redlink_slot.sv
module redlink_slot #(
  parameter int FRAME_W = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vld,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               clr,
  output logic               held,
  output logic               ok,
  output logic [FRAME_W-1:0] frame_q
);

  logic good_in;

  redlink_crc #(.FRAME_W(FRAME_W)) u_crc (
    .frame (frame_in),
    .good  (good_in)
  );

  // capture wins over clear so an arrival on the decision edge survives
  always_ff @(posedge clk) begin
    if (rst) begin
      held <= 1'b0;
      ok   <= 1'b0;
    end else if (vld) begin
      held <= 1'b1;
      ok   <= good_in;
    end else if (clr) begin
      held <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (vld) frame_q <= frame_in;
  end

endmodule

// File: rtl/redlink_pair.sv
module redlink_pair #(
  parameter int TIMEOUT = 1024
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] held,
  output logic       decide
);

  localparam int TW = $clog2(TIMEOUT + 1);

  logic [TW-1:0] wait_cnt;
  logic          lone;

  assign lone   = held[0] ^ held[1];
  assign decide = (held[0] & held[1]) | (lone & (wait_cnt == TW'(TIMEOUT - 1)));

  always_ff @(posedge clk) begin
    if (rst || decide || !lone) wait_cnt <= '0;
    else                        wait_cnt <= wait_cnt + 1'b1;
  end

endmodule

// File: rtl/redlink_evcnt.sv
module redlink_evcnt
  import redlink_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   hit,
  input  pat_t                   pat,
  output logic [N_PAT*CNT_W-1:0] counts
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar p = 0; p < N_PAT; p++) begin : g_cnt
    logic [CNT_W-1:0] c;
    always_ff @(posedge clk) begin
      if (rst) c <= '0;
      else if (hit && pat == pat_t'(p) && c != CNT_MAX) c <= c + 1'b1;
    end
    assign counts[p*CNT_W +: CNT_W] = c;
  end

endmodule

// File: rtl/redlink_sel.sv
module redlink_sel
  import redlink_pkg::*;
#(
  parameter int FRAME_W = 256,
  parameter int TIMEOUT = 1024,
  parameter int CNT_W   = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   a_valid,
  input  logic [FRAME_W-1:0]     a_frame,
  input  logic                   b_valid,
  input  logic [FRAME_W-1:0]     b_frame,
  output logic                   out_valid,
  output logic [FRAME_W-1:0]     out_frame,
  output logic                   dump_req,
  output logic                   sw_trig,
  output logic [PAT_W-1:0]       trig_code,
  output logic [N_PAT*CNT_W-1:0] ev_count
);

  localparam int N_LINK = 2;

  logic [N_LINK-1:0]  vld_v;
  logic [N_LINK-1:0]  held;
  logic [N_LINK-1:0]  ok;
  logic [FRAME_W-1:0] fin [N_LINK];
  logic [FRAME_W-1:0] fq  [N_LINK];
  logic               decide;
  pat_t               pat;
  act_t               act;

  assign vld_v  = {b_valid, a_valid};
  assign fin[0] = a_frame;
  assign fin[1] = b_frame;

  for (genvar l = 0; l < N_LINK; l++) begin : g_link
    redlink_slot #(.FRAME_W(FRAME_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .vld      (vld_v[l]),
      .frame_in (fin[l]),
      .clr      (decide),
      .held     (held[l]),
      .ok       (ok[l]),
      .frame_q  (fq[l])
    );
  end

  redlink_pair #(.TIMEOUT(TIMEOUT)) u_pair (
    .clk    (clk),
    .rst    (rst),
    .held   (held),
    .decide (decide)
  );

  // a missing copy counts as failed and as unequal
  assign pat = {held[0] & ok[0],
                held[1] & ok[1],
                held[0] & held[1] & (fq[0][CRC_W-1:0] == fq[1][CRC_W-1:0])};
  assign act = decode_pat(pat);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_frame <= '0;
      dump_req  <= 1'b0;
      sw_trig   <= 1'b0;
      trig_code <= '0;
    end else begin
      out_valid <= 1'b0;
      dump_req  <= 1'b0;
      sw_trig   <= 1'b0;
      if (decide) begin
        out_valid <= act.take_a | act.take_b;
        dump_req  <= act.dump;
        sw_trig   <= act.trig;
        if (act.take_a)      out_frame <= fq[0];
        else if (act.take_b) out_frame <= fq[1];
        if (act.trig) trig_code <= pat;
      end
    end
  end

  redlink_evcnt #(.CNT_W(CNT_W)) u_evcnt (
    .clk    (clk),
    .rst    (rst),
    .hit    (decide),
    .pat    (pat),
    .counts (ev_count)
  );

endmodule

// File: rtl/redlink_sel_chk.sv
module redlink_sel_chk #(
  parameter int FRAME_W = 256,
  parameter int CNT_W   = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 out_valid,
  input logic [FRAME_W-1:0]   out_frame,
  input logic                 dump_req,
  input logic                 sw_trig,
  input logic [2:0]           trig_code,
  input logic [8*CNT_W-1:0]   ev_count
);

  // R6
  dump_excl_chk: assert property (@(posedge clk) disable iff (rst)
    dump_req |-> (sw_trig && !out_valid));

  // R6
  frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_frame != $past(out_frame)) |-> out_valid);

  // R3
  clean_code_chk: assert property (@(posedge clk) disable iff (rst)
    sw_trig |-> (trig_code != 3'b111));

  // R7
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (trig_code != $past(trig_code)) |-> sw_trig);

  for (genvar p = 0; p < 8; p++) begin : g_mono
    // R11
    cnt_mono_chk: assert property (@(posedge clk) disable iff (rst)
      ev_count[p*CNT_W +: CNT_W] >= $past(ev_count[p*CNT_W +: CNT_W]));
  end

endmodule

bind redlink_sel redlink_sel_chk #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_valid (out_valid),
  .out_frame (out_frame),
  .dump_req  (dump_req),
  .sw_trig   (sw_trig),
  .trig_code (trig_code),
  .ev_count  (ev_count)
);

// File: tb/redlink_sel_tb.sv
`timescale 1ns/1ps
module redlink_sel_tb;

  localparam int FW = 64;
  localparam int TO = 8;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          a_valid, b_valid;
  logic [FW-1:0] a_frame, b_frame;
  logic          out_valid, dump_req, sw_trig;
  logic [FW-1:0] out_frame;
  logic [2:0]    trig_code;
  logic [8*CW-1:0] ev_count;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;
  int exp_cnt [8];
  logic [FW-1:0] last_frame;
  logic [2:0]    last_code;

  always #4 clk = ~clk;

  redlink_sel #(.FRAME_W(FW), .TIMEOUT(TO), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst),
    .a_valid(a_valid), .a_frame(a_frame),
    .b_valid(b_valid), .b_frame(b_frame),
    .out_valid(out_valid), .out_frame(out_frame),
    .dump_req(dump_req), .sw_trig(sw_trig),
    .trig_code(trig_code), .ev_count(ev_count)
  );

  function automatic logic [31:0] bcrc(input logic [31:0] pl);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 31; i >= 0; i--) begin
      if (c[31] ^ pl[i]) c = (c << 1) ^ 32'h04C1_1DB7;
      else               c = c << 1;
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  task automatic put(input logic av, input logic [FW-1:0] af,
                     input logic bv, input logic [FW-1:0] bf);
    @(negedge clk);
    a_valid = av; a_frame = af; b_valid = bv; b_frame = bf;
    @(negedge clk);
    a_valid = 0; b_valid = 0;
  endtask

  task automatic quiet(input string req);
    chk(req, {61'd0, out_valid, dump_req, sw_trig}, 64'd0);
  endtask

  // expected outcome for pattern p, derived from the decision table
  task automatic exp_dec(input string req, input int p,
                         input logic [FW-1:0] fa, input logic [FW-1:0] fb);
    logic fwd_a, fwd_b, dmp, trg;
    fwd_a = (p == 7) || (p == 5) || (p == 4);
    fwd_b = (p == 3) || (p == 2);
    dmp   = (p == 0) || (p == 1) || (p == 6);
    trg   = (p != 7);
    if (fwd_a) last_frame = fa;
    if (fwd_b) last_frame = fb;
    if (trg)   last_code  = 3'(p);
    chk(req, {61'd0, out_valid, dump_req, sw_trig}, {61'd0, fwd_a | fwd_b, dmp, trg});
    chk(req, out_frame, last_frame);
    chk("R7", trig_code, last_code);
    if (exp_cnt[p] < 7) exp_cnt[p]++;
  endtask

  task automatic mk(input int p, input logic [31:0] pl,
                    output logic [FW-1:0] fa, output logic [FW-1:0] fb);
    logic [FW-1:0] g;
    g = {pl, bcrc(pl)};
    case (p)
      7: begin fa = g;          fb = g; end
      6: begin fa = g;          fb = {pl ^ 32'h1, bcrc(pl ^ 32'h1)}; end
      5: begin fa = g;          fb = g ^ (64'h1 << 40); end
      4: begin fa = g;          fb = g ^ 64'h1; end
      3: begin fa = g ^ (64'h1 << 40); fb = g; end
      2: begin fa = g ^ 64'h1;  fb = g; end
      1: begin fa = g ^ 64'h1;  fb = g ^ 64'h1; end
      default: begin fa = g ^ 64'h1; fb = g ^ 64'h2; end
    endcase
  endtask

  function automatic int pat_of(input logic [FW-1:0] fa, input logic [FW-1:0] fb);
    return {29'd0, bcrc(fa[63:32]) == fa[31:0], bcrc(fb[63:32]) == fb[31:0],
            fa[31:0] == fb[31:0]};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      report();
    end
  end

  initial begin
    logic [FW-1:0] fa, fb, fa2;
    string rq;
    a_valid = 0; b_valid = 0; a_frame = '0; b_frame = '0;
    last_frame = '0; last_code = '0;
    for (int i = 0; i < 8; i++) exp_cnt[i] = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R12 reset state
    quiet("R12");
    chk("R12", out_frame, 64'd0);
    chk("R12", trig_code, 64'd0);
    chk("R12", ev_count, 64'd0);

    // R1..R7 sweep: every pattern under three arrival orders
    for (int ord = 0; ord < 3; ord++) begin
      for (int p = 0; p < 8; p++) begin
        mk(p, 32'h9E37_79B9 * (ord * 8 + p + 1) ^ 32'h5A5A_0F0F, fa, fb);
        chk("R1", pat_of(fa, fb), p);
        case (ord)
          0: put(1, fa, 1, fb);
          1: begin put(1, fa, 0, '0); repeat (2) @(negedge clk); quiet("R2"); put(0, '0, 1, fb); end
          default: begin put(0, '0, 1, fb); repeat (5) @(negedge clk); quiet("R2"); put(1, fa, 0, '0); end
        endcase
        @(negedge clk);
        rq = (p == 7) ? "R3" : (p == 5 || p == 4) ? "R4" : (p == 3 || p == 2) ? "R5" : "R6";
        exp_dec(rq, p, fa, fb);
        @(negedge clk);
        quiet("R7");
      end
    end
    for (int p = 0; p < 8; p++) chk("R11", ev_count[p*CW +: CW], exp_cnt[p]);

    // R8 lone good A -> pattern 100
    mk(7, 32'h0BAD_F00D, fa, fb);
    put(1, fa, 0, '0);
    repeat (TO - 1) @(negedge clk);
    quiet("R8");
    @(negedge clk);
    exp_dec("R8", 4, fa, fb);
    // R8 lone good B -> pattern 010
    mk(7, 32'h1357_9BDF, fa, fb);
    put(0, '0, 1, fb);
    repeat (TO - 1) @(negedge clk);
    quiet("R8");
    @(negedge clk);
    exp_dec("R8", 2, fa, fb);
    // R8 lone bad A -> pattern 000
    mk(0, 32'h2468_ACE0, fa, fb);
    put(1, fa, 0, '0);
    repeat (TO) @(negedge clk);
    exp_dec("R8", 0, fa, fb);

    // R9 replacement does not restart the wait
    mk(7, 32'hAAAA_5555, fa, fb);
    mk(7, 32'hC0FF_EE00, fa2, fb);
    put(1, fa, 0, '0);
    repeat (2) @(negedge clk);
    put(1, fa2, 0, '0);
    repeat (TO - 5) @(negedge clk);
    quiet("R9");
    @(negedge clk);
    exp_dec("R9", 4, fa2, fb);

    // R10 new A captured on the decision edge
    mk(7, 32'h1111_2222, fa, fb);
    mk(7, 32'h3333_4444, fa2, fb);
    @(negedge clk);
    a_valid = 1; a_frame = fa; b_valid = 1; b_frame = fa;
    @(negedge clk);
    a_valid = 1; a_frame = fa2; b_valid = 0;
    @(negedge clk);
    a_valid = 0;
    exp_dec("R10", 7, fa, fa);
    b_valid = 1; b_frame = fa2;
    @(negedge clk);
    b_valid = 0;
    quiet("R10");
    @(negedge clk);
    exp_dec("R10", 7, fa2, fa2);

    // R11 saturation of the clean-pattern counter
    for (int k = 0; k < 8; k++) begin
      mk(7, 32'h7777_0000 + k, fa, fb);
      put(1, fa, 1, fb);
      @(negedge clk);
      exp_dec("R3", 7, fa, fb);
    end
    for (int p = 0; p < 8; p++) chk("R11", ev_count[p*CW +: CW], exp_cnt[p]);
    chk("R11", ev_count[7*CW +: CW], 64'd7);

    report();
  end

endmodule